// File: doc/BRIEF.md
# Configuration Address Translating Bridge

This block sits between a host register port and a downstream configuration transaction port. It holds a 32-bit index register in one 4 KiB window and decodes accesses to a second 4 KiB data window. Every access to the data window turns the stored index, together with the low bits of the access offset, into one canonical configuration address. That address is sent downstream as a single request with the access length and, for writes, the data.

Three index encodings are recognised, and they are tested in a fixed priority order. When the top bit is set, the index passes through with the low two offset bits OR-ed in. When only the low bit is set, the word is treated as already in bus/device/function form. Otherwise the index is a one-hot slot select: the lowest set bit in the upper field gives a binary device number. This third form is how firmware that drives one address line per slot reaches devices on a bus that expects device numbers.

Both the host side and the downstream request side use valid/ready. A source raises valid and must hold valid and every qualifying field stable until it sees ready high at a clock edge. On the host side, ready comes late for any data-window access: it waits for downstream acceptance on a write, and for the downstream response on a read.

Top module: `cfgx_bridge`

## Requirements
- R1: If index bit 31 is set, the downstream address is the index OR-ed with data-window offset bits 1:0, whatever bit 0 holds.
- R2: If bit 31 is clear and bit 0 is set, the downstream address is the index with bits 2:0 replaced by offset bits 2:0.
- R3: If bits 31 and 0 are both clear, the downstream address carries, in bits 31:11, the position (11 to 30) of the lowest set index bit among bits 31:11. Bits 10:3 are copied from the index and bits 2:0 come from the offset.
- R4: In the R3 case with index bits 31:11 all zero, downstream address bits 31:11 are all ones.
- R5: `up_size` encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, and `dn_len` carries that byte count. A data-window write sends the little-endian bytes at lanes offset[1:0] upward, right-aligned on `dn_wdata`, with `dn_write` = 1.
- R6: A data-window read keeps `up_ready` low until the downstream response has arrived. It then returns the response masked to the access length and shifted to byte lane offset[1:0].
- R7: Index-window writes update only the byte lanes selected by size and offset[1:0], and they apply to the next data access. Index-window reads return the stored word unchanged. Neither kind of index access issues a downstream request.
- R8: Reset clears the index to zero and abandons any outstanding downstream request. `dn_valid` is low after reset.
- R9: A downstream request stays valid with stable fields until `dn_ready`, and each data access makes exactly one request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_valid | input | 1 | Host access valid |
| up_ready | output | 1 | Host access completes at this edge |
| up_write | input | 1 | 1 = write, 0 = read |
| up_addr | input | WIN_W+1 | Bit WIN_W selects the data window (1) or index window (0); lower bits are the byte offset |
| up_size | input | 2 | Access size code (R5) |
| up_wdata | input | 32 | Host write data, little-endian byte lanes |
| up_rdata | output | 32 | Host read data, valid with up_ready |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream request accepted |
| dn_write | output | 1 | Downstream request is a write |
| dn_addr | output | 32 | Translated configuration address |
| dn_len | output | 3 | Transfer length in bytes |
| dn_wdata | output | 32 | Right-aligned write data |
| dn_rvalid | input | 1 | Downstream read response valid |
| dn_rdata | input | 32 | Right-aligned read response |

## Verification
A table of index words exercises each encoding. It includes pass-through words with bit 0 set or clear, which shows that bit 31 takes priority. It includes a type-1 word, whose low three bits are overwritten. It includes one-hot words at the lowest slot, a middle slot and the highest slot, which show that the lowest set bit wins and that the number lands at bit 11. It includes a word with no slot bit, which gives the all-ones field. Offsets with bit 2 set separate the two-bit merge of the pass-through form from the three-bit merge of the other forms. Varying the size and the response delay shows the lane placement of read data and the stall on the host side. Byte-wide index writes, a held-off `dn_ready` and a reset during an open read cover the remaining rules.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  localparam int CFG_W   = 32;
  localparam int LANES   = CFG_W / 8;
  localparam int DEV_LO  = 11;
  localparam int DEV_W   = 5;
  localparam int LEN_W   = 3;

  typedef enum logic [1:0] {
    XS_BYTE = 2'd0,
    XS_HALF = 2'd1,
    XS_WORD = 2'd2
  } xsize_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } cfgx_state_e;

  typedef struct packed {
    logic             wr;
    logic [CFG_W-1:0] addr;
    logic [LEN_W-1:0] len;
    logic [CFG_W-1:0] wdata;
  } dn_req_t;
endpackage

// File: rtl/cfgx_index_reg.sv
module cfgx_index_reg
  import cfgx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LANES-1:0] be,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] idx
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (wr_en) begin
      for (int b = 0; b < LANES; b++) begin
        if (be[b]) idx[8*b +: 8] <= wdata[8*b +: 8];
      end
    end
  end
endmodule

// File: rtl/cfgx_xlate.sv
module cfgx_xlate
  import cfgx_pkg::*;
(
  input  logic [CFG_W-1:0] idx,
  input  logic [2:0]       off,
  output logic [CFG_W-1:0] addr
);
  localparam int HI_W = CFG_W - DEV_LO;

  logic [DEV_W-1:0] dev;
  logic             found;

  // Scan from the top down so that the lowest set bit is the one that sticks.
  always_comb begin
    dev   = '1;
    found = 1'b0;
    for (int i = CFG_W - 1; i >= DEV_LO; i--) begin
      if (idx[i]) begin
        dev   = DEV_W'(i);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    if (idx[CFG_W-1]) begin
      addr = idx | {{(CFG_W-2){1'b0}}, off[1:0]};
    end else if (idx[0]) begin
      addr = {idx[CFG_W-1:3], off};
    end else begin
      addr = {found ? {{(HI_W-DEV_W){1'b0}}, dev} : {HI_W{1'b1}},
              idx[DEV_LO-1:3], off};
    end
  end
endmodule

// File: rtl/cfgx_lane.sv
module cfgx_lane
  import cfgx_pkg::*;
(
  input  xsize_e           size,
  input  logic [1:0]       off,
  input  logic [CFG_W-1:0] host_wdata,
  input  logic [CFG_W-1:0] rsp_data,
  output logic [LANES-1:0] be,
  output logic [LEN_W-1:0] len,
  output logic [CFG_W-1:0] wr_right,
  output logic [CFG_W-1:0] rd_placed
);
  logic [LANES-1:0] lane_mask;
  logic [CFG_W-1:0] bit_mask;
  logic [4:0]       shamt;

  always_comb begin
    unique case (size)
      XS_BYTE: begin lane_mask = 4'b0001; len = 3'd1; end
      XS_HALF: begin lane_mask = 4'b0011; len = 3'd2; end
      default: begin lane_mask = 4'b1111; len = 3'd4; end
    endcase
  end

  for (genvar b = 0; b < LANES; b++) begin : g_mask
    assign bit_mask[8*b +: 8] = {8{lane_mask[b]}};
  end

  assign shamt     = {off, 3'b000};
  assign be        = lane_mask << off;
  assign wr_right  = (host_wdata >> shamt) & bit_mask;
  assign rd_placed = (rsp_data & bit_mask) << shamt;
endmodule

// File: rtl/cfgx_bridge.sv
module cfgx_bridge
  import cfgx_pkg::*;
#(
  parameter int WIN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_valid,
  output logic             up_ready,
  input  logic             up_write,
  input  logic [WIN_W:0]   up_addr,
  input  logic [1:0]       up_size,
  input  logic [CFG_W-1:0] up_wdata,
  output logic [CFG_W-1:0] up_rdata,
  output logic             dn_valid,
  input  logic             dn_ready,
  output logic             dn_write,
  output logic [CFG_W-1:0] dn_addr,
  output logic [LEN_W-1:0] dn_len,
  output logic [CFG_W-1:0] dn_wdata,
  input  logic             dn_rvalid,
  input  logic [CFG_W-1:0] dn_rdata
);
  cfgx_state_e      st;
  dn_req_t          req_q;
  logic [CFG_W-1:0] rdata_q;
  logic [CFG_W-1:0] idx;
  logic [CFG_W-1:0] xaddr;
  logic [LANES-1:0] be;
  logic [LEN_W-1:0] len;
  logic [CFG_W-1:0] wr_right;
  logic [CFG_W-1:0] rd_placed;
  logic             is_data;
  logic [2:0]       off;
  logic             idx_wr;
  logic             unused_hi;

  assign is_data   = up_addr[WIN_W];
  assign off       = up_addr[2:0];
  assign unused_hi = ^up_addr[WIN_W-1:3];
  assign idx_wr    = (st == ST_IDLE) && up_valid && !is_data && up_write;

  cfgx_index_reg u_idx (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (idx_wr),
    .be    (be),
    .wdata (up_wdata),
    .idx   (idx)
  );

  cfgx_xlate u_xlate (
    .idx  (idx),
    .off  (off),
    .addr (xaddr)
  );

  cfgx_lane u_lane (
    .size       (xsize_e'(up_size)),
    .off        (off[1:0]),
    .host_wdata (up_wdata),
    .rsp_data   (dn_rdata),
    .be         (be),
    .len        (len),
    .wr_right   (wr_right),
    .rd_placed  (rd_placed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      req_q   <= '0;
      rdata_q <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (up_valid && is_data) begin
            req_q.wr    <= up_write;
            req_q.addr  <= xaddr;
            req_q.len   <= len;
            req_q.wdata <= wr_right;
            st          <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (dn_ready) st <= req_q.wr ? ST_DONE : ST_WAIT;
        end
        ST_WAIT: begin
          if (dn_rvalid) begin
            rdata_q <= rd_placed;
            st      <= ST_DONE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign up_ready = ((st == ST_IDLE) && up_valid && !is_data) || (st == ST_DONE);
  assign up_rdata = (st == ST_DONE) ? rdata_q : idx;
  assign dn_valid = (st == ST_ISSUE);
  assign dn_write = req_q.wr;
  assign dn_addr  = req_q.addr;
  assign dn_len   = req_q.len;
  assign dn_wdata = req_q.wdata;

  AST_DN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr) && $stable(dn_len))); // R9

  AST_RD_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (up_ready && up_valid && is_data && !up_write) |-> $past(dn_rvalid)); // R6

  AST_SLOT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !idx[31] && !idx[0] && (|idx[31:11]))
      |-> (idx[dn_addr[15:11]] && dn_addr[31:16] == '0 && dn_addr[15:11] >= 5'd11)); // R3

  AST_NO_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !idx[31] && !idx[0] && !(|idx[31:11])) |-> (&dn_addr[31:11])); // R4

  AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !dn_valid); // R8
endmodule

// File: tb/cfgx_bridge_test.sv
`timescale 1ns/1ps
module cfgx_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        up_valid = 1'b0;
  logic        up_ready;
  logic        up_write = 1'b0;
  logic [12:0] up_addr = '0;
  logic [1:0]  up_size = 2'd2;
  logic [31:0] up_wdata = '0;
  logic [31:0] up_rdata;
  logic        dn_valid;
  logic        dn_ready = 1'b1;
  logic        dn_write;
  logic [31:0] dn_addr;
  logic [2:0]  dn_len;
  logic [31:0] dn_wdata;
  logic        dn_rvalid = 1'b0;
  logic [31:0] dn_rdata = '0;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  cfgx_bridge uut (.*);

  // Downstream model: all updates at the falling edge.
  int          ready_gap = 0;
  int          rsp_delay = 0;
  int          rsp_cnt = 0;
  bit          rsp_pend = 0;
  int          hs_count = 0;
  logic [31:0] cap_addr, cap_wdata;
  logic [2:0]  cap_len;
  logic        cap_wr;

  function automatic logic [31:0] rsp_for(logic [31:0] a);
    return {a[15:0] ^ 16'h3C3C, 16'hA5C3};
  endfunction

  always @(negedge clk) begin
    logic r;
    dn_rvalid = 1'b0;
    if (!rst_n) begin
      rsp_pend = 0;
      dn_ready = 1'b1;
    end else begin
      if (rsp_pend) begin
        if (rsp_cnt == 0) begin
          dn_rvalid = 1'b1;
          dn_rdata  = rsp_for(cap_addr);
          rsp_pend  = 0;
        end else begin
          rsp_cnt--;
        end
      end
      r = !(dn_valid && ready_gap > 0);
      if (!r) ready_gap--;
      dn_ready = r;
      if (dn_valid && r) begin
        hs_count++;
        cap_addr  = dn_addr;
        cap_len   = dn_len;
        cap_wdata = dn_wdata;
        cap_wr    = dn_write;
        if (!dn_write) begin
          rsp_pend = 1;
          rsp_cnt  = rsp_delay;
        end
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [12:0] a, input logic [1:0] sz,
                     input logic [31:0] wd, output logic [31:0] rd, output int waits);
    @(negedge clk);
    up_valid = 1'b1; up_write = wr; up_addr = a; up_size = sz; up_wdata = wd;
    waits = 0;
    #1;
    while (!up_ready) begin
      @(negedge clk); #1;
      waits++;
    end
    rd = up_rdata;
    @(posedge clk);
    @(negedge clk);
    up_valid = 1'b0;
  endtask

  function automatic logic [31:0] place(logic [31:0] v, logic [1:0] sz, logic [1:0] o);
    logic [31:0] m;
    m = (sz == 2'd0) ? 32'h0000_00FF : (sz == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    return (v & m) << (8 * o);
  endfunction

  // {index, offset[2:0], size, expected dn_addr}
  localparam logic [68:0] VEC [8] = '{
    {32'h8000_1234, 3'd7, 2'd0, 32'h8000_1237},  // R1 offset bit 2 dropped
    {32'h8000_0001, 3'd2, 2'd1, 32'h8000_0003},  // R1 wins over bit 0
    {32'h0012_3405, 3'd6, 2'd1, 32'h0012_3406},  // R2
    {32'h0000_0BA8, 3'd4, 2'd2, 32'h0000_5BAC},  // R3 slot 11
    {32'h4001_0010, 3'd0, 2'd2, 32'h0000_8010},  // R3 lowest of two
    {32'h0C00_0000, 3'd1, 2'd0, 32'h0000_D001},  // R3 slot 26
    {32'h4000_0000, 3'd3, 2'd0, 32'h0000_F003},  // R3 slot 30
    {32'h0000_07F8, 3'd2, 2'd1, 32'hFFFF_FFFA}   // R4
  };

  initial begin : wd
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int w, hs0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8: reset state
    chk("R8 dn_valid after reset", {31'b0, dn_valid}, 32'h0);
    acc(1'b0, 13'h000, 2'd2, 32'h0, rd, w);
    chk("R8 index cleared", rd, 32'h0);
    acc(1'b0, 13'h1005, 2'd0, 32'h0, rd, w);
    chk("R4 zero index address", cap_addr, 32'hFFFF_F805);

    // Table walk: R1..R4, R5 length, R6 placement
    for (int i = 0; i < 8; i++) begin
      logic [31:0] ix, ex;
      logic [2:0]  o;
      logic [1:0]  s;
      {ix, o, s, ex} = VEC[i];
      rsp_delay = i % 3;
      acc(1'b1, 13'h000, 2'd2, ix, rd, w);
      acc(1'b0, {1'b1, 9'b0, o}, s, 32'h0, rd, w);
      chk($sformatf("R1-R4 vec%0d addr", i), cap_addr, ex);
      chk($sformatf("R5 vec%0d len", i), {29'b0, cap_len}, 32'd1 << s);
      chk($sformatf("R6 vec%0d rdata", i), rd, place(rsp_for(ex), s, o[1:0]));
    end

    // R7: byte-lane index writes, readback, no downstream traffic
    hs0 = hs_count;
    acc(1'b1, 13'h000, 2'd2, 32'h0, rd, w);
    acc(1'b1, 13'h001, 2'd0, 32'h0000_5A00, rd, w);
    acc(1'b0, 13'h000, 2'd2, 32'h0, rd, w);
    chk("R7 byte write", rd, 32'h0000_5A00);
    acc(1'b1, 13'h002, 2'd1, 32'h1234_0000, rd, w);
    acc(1'b0, 13'h000, 2'd2, 32'h0, rd, w);
    chk("R7 half write", rd, 32'h1234_5A00);
    chk("R7 no downstream request", hs_count, hs0);

    // R5: data-window write lane extraction
    acc(1'b1, 13'h000, 2'd2, 32'h8000_0000, rd, w);
    acc(1'b1, 13'h1002, 2'd1, 32'hBEEF_0000, rd, w);
    chk("R5 write data", cap_wdata, 32'h0000_BEEF);
    chk("R5 write flag", {31'b0, cap_wr}, 32'h1);
    chk("R5 write addr", cap_addr, 32'h8000_0002);

    // R6: stall while the response is outstanding
    rsp_delay = 6;
    acc(1'b0, 13'h1000, 2'd2, 32'h0, rd, w);
    chk("R6 stall length", {31'b0, (w > 6)}, 32'h1);
    chk("R6 stalled rdata", rd, rsp_for(32'h8000_0000));
    rsp_delay = 0;

    // R9: held-off downstream ready, single request
    hs0 = hs_count;
    ready_gap = 3;
    acc(1'b0, 13'h1001, 2'd0, 32'h0, rd, w);
    chk("R9 one request", hs_count, hs0 + 1);
    chk("R9 addr after hold", cap_addr, 32'h8000_0001);

    // R8: reset with a read outstanding
    rsp_delay = 40;
    @(negedge clk);
    up_valid = 1'b1; up_write = 1'b0; up_addr = 13'h1000; up_size = 2'd2;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    up_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rsp_delay = 0;
    repeat (3) @(negedge clk);
    chk("R8 request dropped", {30'b0, dn_valid, up_ready}, 32'h0);
    acc(1'b0, 13'h000, 2'd2, 32'h0, rd, w);
    chk("R8 index cleared again", rd, 32'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule